// File: doc/BRIEF.md
# Watchdog and Sleep Interval Timer

This block counts enable pulses from a slow oscillator and does two jobs with that count. It raises a periodic sleep-wake interrupt, and it acts as a watchdog: if software does not restart it in time, it issues a system reset pulse. A single 2-bit period code sets both intervals. The sleep interval is one of four power-of-two tick counts, and the watchdog timeout is a fixed number of those intervals. The two therefore cannot be chosen independently.

The slow tick comes from one of two enable inputs: an internal low-power oscillator or an external 32.768 kHz crystal. A select bit chooses between them. Software restarts the timer by strobing the restart input, which stands for a write of any value. A sticky cause bit records that a watchdog reset happened. The watchdog pulse it records does not clear it. Only power-on reset or a software clear strobe clears it.

Top module: `wdt_sleep_timer`

## Requirements
- R1: After power-on reset, `wdt_rst_o`, `wdt_cause_o` and `sleep_irq_o` are all 0.
- R2: Only the tick input chosen by `src_sel_i` advances the timer (0 = internal, 1 = external). Pulses on the other tick input have no effect on either output.
- R3: With period code k, `sleep_irq_o` is a one-cycle pulse once every 2^(TAP_BASE+TAP_STEP*k) counted ticks (4, 16, 64 or 256 with the defaults). It goes high in the cycle after the tick that completes the interval.
- R4: A cycle with `kick_i` high clears the tick count and the count of elapsed intervals. A tick in that same cycle is not counted, so no interrupt and no reset follow it.
- R5: After WDT_PERIODS (default 3) complete intervals with no restart, `wdt_rst_o` goes high in the cycle after the final tick. It stays high for exactly RST_LEN (default 4) clocks, and counting starts again from zero.
- R6: `wdt_cause_o` goes to 1 together with the reset pulse and stays 1 through the pulse and afterwards. It returns to 0 only on `cause_clr_i` or power-on reset. A trip in the same cycle as a clear leaves it at 1.
- R7: A change of `src_sel_i` clears the tick and interval counts. A tick in the cycle of the change is not counted.
- R8: A change of `period_sel_i` takes effect on the next tick and does not clear the count. If the count's low bits for the new code are all ones, that tick completes an interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| tick_int_i | input | 1 | Enable pulse from the internal low-power oscillator |
| tick_ext_i | input | 1 | Enable pulse from the external crystal oscillator |
| src_sel_i | input | 1 | Tick source: 0 internal, 1 external |
| period_sel_i | input | 2 | Period code shared by sleep interval and watchdog timeout |
| kick_i | input | 1 | Restart strobe (any software write) |
| cause_clr_i | input | 1 | Software clear of the reset-cause bit |
| wdt_rst_o | output | 1 | Watchdog reset pulse, RST_LEN clocks long |
| wdt_cause_o | output | 1 | Sticky flag: a watchdog reset has occurred |
| sleep_irq_o | output | 1 | One-cycle sleep-wake interrupt pulse |

## Verification
The hardest cases to reach are a period-code change at a moment when the running count already has all-ones low bits for the new code, and a source switch that coincides with a tick. Random stimulus seldom lines either up. Directed sequences build them: the count is stepped to a known value under the longest code before the switch to the shortest code, and both tick inputs are held high while the source toggles. Long random runs with rare restarts then drive repeated trips. This also exercises cause clears that land during and after a reset pulse.

// File: rtl/wdt_sleep_pkg.sv
package wdt_sleep_pkg;

  // Number of low count bits that define the interval for a period code.
  function automatic int unsigned tap_width(input int unsigned base,
                                            input int unsigned step,
                                            input int unsigned code);
    return base + step * code;
  endfunction

  // Width of the free-running tick counter: enough for the longest tap.
  function automatic int unsigned count_width(input int unsigned base,
                                              input int unsigned step);
    return base + step * 3;
  endfunction

endpackage

// File: rtl/wdt_tick_sel.sv
module wdt_tick_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_int_i,
  input  logic tick_ext_i,
  input  logic src_sel_i,
  output logic tick_o,
  output logic src_chg_o
);
  logic src_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= 1'b0;
    else        src_q <= src_sel_i;
  end

  assign src_chg_o = src_sel_i ^ src_q;
  assign tick_o    = (src_sel_i ? tick_ext_i : tick_int_i) & ~src_chg_o;
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned TAP_BASE = 2,
  parameter int unsigned TAP_STEP = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       restart_i,
  input  logic       trip_i,
  input  logic [1:0] period_sel_i,
  output logic       period_evt_o
);
  import wdt_sleep_pkg::*;

  localparam int unsigned CNT_W = count_width(TAP_BASE, TAP_STEP);

  logic [CNT_W-1:0] cnt_q;
  logic [3:0]       tap_hit;

  for (genvar k = 0; k < 4; k++) begin : g_tap
    localparam int unsigned TW = tap_width(TAP_BASE, TAP_STEP, k);
    assign tap_hit[k] = &cnt_q[TW-1:0];
  end

  assign period_evt_o = tick_i & ~restart_i & tap_hit[period_sel_i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (restart_i || trip_i) cnt_q <= '0;
    else if (tick_i)             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdt_miss_ctr.sv
module wdt_miss_ctr #(
  parameter int unsigned WDT_PERIODS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic period_evt_i,
  output logic trip_o
);
  localparam int unsigned MISS_W = $clog2(WDT_PERIODS + 1);
  localparam logic [MISS_W-1:0] LAST = MISS_W'(WDT_PERIODS - 1);

  logic [MISS_W-1:0] miss_q;

  assign trip_o = period_evt_i & (miss_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            miss_q <= '0;
    else if (restart_i)    miss_q <= '0;
    else if (trip_o)       miss_q <= '0;
    else if (period_evt_i) miss_q <= miss_q + 1'b1;
  end
endmodule

// File: rtl/wdt_rst_gen.sv
module wdt_rst_gen #(
  parameter int unsigned RST_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_i,
  input  logic cause_clr_i,
  output logic wdt_rst_o,
  output logic wdt_cause_o
);
  localparam int unsigned LEN_W = $clog2(RST_LEN + 1);

  logic [LEN_W-1:0] left_q;
  logic             cause_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     left_q <= '0;
    else if (trip_i && left_q == '0) left_q <= LEN_W'(RST_LEN);
    else if (left_q != '0)          left_q <= left_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cause_q <= 1'b0;
    else if (trip_i)      cause_q <= 1'b1;
    else if (cause_clr_i) cause_q <= 1'b0;
  end

  assign wdt_rst_o   = (left_q != '0);
  assign wdt_cause_o = cause_q;
endmodule

// File: rtl/wdt_sleep_timer.sv
module wdt_sleep_timer #(
  parameter int unsigned TAP_BASE    = 2,
  parameter int unsigned TAP_STEP    = 2,
  parameter int unsigned WDT_PERIODS = 3,
  parameter int unsigned RST_LEN     = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_int_i,
  input  logic       tick_ext_i,
  input  logic       src_sel_i,
  input  logic [1:0] period_sel_i,
  input  logic       kick_i,
  input  logic       cause_clr_i,
  output logic       wdt_rst_o,
  output logic       wdt_cause_o,
  output logic       sleep_irq_o
);
  // Named internal events, also observed by the bound checker.
  logic tick_w;
  logic src_chg_w;
  logic restart_w;
  logic period_evt_w;
  logic trip_w;
  logic irq_q;

  wdt_tick_sel u_tick_sel (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_int_i (tick_int_i),
    .tick_ext_i (tick_ext_i),
    .src_sel_i  (src_sel_i),
    .tick_o     (tick_w),
    .src_chg_o  (src_chg_w)
  );

  assign restart_w = kick_i | src_chg_w;

  wdt_prescaler #(
    .TAP_BASE (TAP_BASE),
    .TAP_STEP (TAP_STEP)
  ) u_prescaler (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick_w),
    .restart_i    (restart_w),
    .trip_i       (trip_w),
    .period_sel_i (period_sel_i),
    .period_evt_o (period_evt_w)
  );

  wdt_miss_ctr #(
    .WDT_PERIODS (WDT_PERIODS)
  ) u_miss (
    .clk          (clk),
    .rst_n        (rst_n),
    .restart_i    (restart_w),
    .period_evt_i (period_evt_w),
    .trip_o       (trip_w)
  );

  wdt_rst_gen #(
    .RST_LEN (RST_LEN)
  ) u_rst_gen (
    .clk         (clk),
    .rst_n       (rst_n),
    .trip_i      (trip_w),
    .cause_clr_i (cause_clr_i),
    .wdt_rst_o   (wdt_rst_o),
    .wdt_cause_o (wdt_cause_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= period_evt_w;
  end

  assign sleep_irq_o = irq_q;
endmodule

// File: rtl/wdt_sleep_timer_chk.sv
module wdt_sleep_timer_chk #(
  parameter int unsigned RST_LEN = 4
) (
  input logic clk,
  input logic rst_n,
  input logic kick_i,
  input logic src_sel_i,
  input logic cause_clr_i,
  input logic wdt_rst_o,
  input logic wdt_cause_o,
  input logic sleep_irq_o,
  input logic trip,
  input logic period_evt
);
  localparam int unsigned HC_W = $clog2(RST_LEN + 1) + 1;

  logic [HC_W-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hi_cnt <= '0;
    else if (wdt_rst_o) hi_cnt <= hi_cnt + 1'b1;
    else                hi_cnt <= '0;
  end

  p_rst_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_o |-> (hi_cnt < HC_W'(RST_LEN)));

  p_rst_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdt_rst_o) |-> (hi_cnt == HC_W'(RST_LEN)));

  p_trip_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trip |=> wdt_rst_o);

  p_cause_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trip |=> wdt_cause_o);

  p_cause_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_cause_o && !cause_clr_i) |=> wdt_cause_o);

  p_irq_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_irq_o |=> !sleep_irq_o);

  p_irq_from_evt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    period_evt |=> sleep_irq_o);

  p_kick_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    kick_i |=> !sleep_irq_o);

  p_kick_trip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    kick_i |-> !trip);

  p_src_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel_i != $past(src_sel_i)) |=> !sleep_irq_o);
endmodule

bind wdt_sleep_timer wdt_sleep_timer_chk #(
  .RST_LEN (RST_LEN)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .kick_i      (kick_i),
  .src_sel_i   (src_sel_i),
  .cause_clr_i (cause_clr_i),
  .wdt_rst_o   (wdt_rst_o),
  .wdt_cause_o (wdt_cause_o),
  .sleep_irq_o (sleep_irq_o),
  .trip        (trip_w),
  .period_evt  (period_evt_w)
);

// File: tb/test_wdt_sleep_timer.sv
module test_wdt_sleep_timer;
  localparam int TB_BASE = 2;
  localparam int TB_STEP = 2;
  localparam int TB_MISS = 3;
  localparam int TB_LEN  = 4;
  localparam int TB_MOD  = 1 << (TB_BASE + 3 * TB_STEP);

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_int_i = 1'b0;
  logic       tick_ext_i = 1'b0;
  logic       src_sel_i = 1'b0;
  logic [1:0] period_sel_i = 2'd0;
  logic       kick_i = 1'b0;
  logic       cause_clr_i = 1'b0;
  logic       wdt_rst_o;
  logic       wdt_cause_o;
  logic       sleep_irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // Reference model state
  int m_src, m_cnt, m_miss, m_left, m_cause, m_irq;

  always #4 clk = ~clk;

  wdt_sleep_timer i_wdt_sleep_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_int_i   (tick_int_i),
    .tick_ext_i   (tick_ext_i),
    .src_sel_i    (src_sel_i),
    .period_sel_i (period_sel_i),
    .kick_i       (kick_i),
    .cause_clr_i  (cause_clr_i),
    .wdt_rst_o    (wdt_rst_o),
    .wdt_cause_o  (wdt_cause_o),
    .sleep_irq_o  (sleep_irq_o)
  );

  function automatic int interval_ticks(input int code);
    return 1 << (TB_BASE + TB_STEP * code);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_src = 0; m_cnt = 0; m_miss = 0; m_left = 0; m_cause = 0; m_irq = 0;
  endtask

  // Advance the model by one clock given the inputs of that cycle.
  task automatic model_step(input int ti, input int te, input int src,
                            input int ps, input int kk, input int cc);
    int tk, chg, evt, trp;
    tk  = (src != 0) ? te : ti;
    chg = (src != m_src);
    m_src = src;
    evt = 0; trp = 0;
    if (kk != 0 || chg != 0) begin
      m_cnt = 0; m_miss = 0;
    end else if (tk != 0) begin
      if ((m_cnt % interval_ticks(ps)) == interval_ticks(ps) - 1) evt = 1;
      m_cnt = (m_cnt + 1) % TB_MOD;
      if (evt != 0) begin
        m_miss++;
        if (m_miss == TB_MISS) begin
          trp = 1; m_miss = 0; m_cnt = 0;
        end
      end
    end
    m_irq = evt;
    if (trp != 0 && m_left == 0) m_left = TB_LEN;
    else if (m_left > 0)         m_left--;
    if (trp != 0)     m_cause = 1;
    else if (cc != 0) m_cause = 0;
  endtask

  // Called at a falling edge: drive, clock, compare at the next falling edge.
  task automatic step(input int ti, input int te, input int src,
                      input int ps, input int kk, input int cc);
    tick_int_i = ti[0]; tick_ext_i = te[0]; src_sel_i = src[0];
    period_sel_i = ps[1:0]; kick_i = kk[0]; cause_clr_i = cc[0];
    model_step(ti, te, src, ps, kk, cc);
    @(posedge clk);
    @(negedge clk);
    check(sleep_irq_o == m_irq[0],   "R3 sleep_irq", sleep_irq_o, m_irq);
    check(wdt_rst_o == (m_left > 0), "R5 wdt_rst",   wdt_rst_o, m_left > 0);
    check(wdt_cause_o == m_cause[0], "R6 cause",     wdt_cause_o, m_cause);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int seen, n, src;
    void'($urandom(32'h5EED_0042));
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    check(wdt_rst_o == 1'b0,   "R1 wdt_rst",   wdt_rst_o, 0);
    check(wdt_cause_o == 1'b0, "R1 cause",     wdt_cause_o, 0);
    check(sleep_irq_o == 1'b0, "R1 sleep_irq", sleep_irq_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: ticks only on the unselected input never reach the outputs
    seen = 0;
    for (int i = 0; i < 300; i++) begin
      step(0, 1, 0, 0, 0, 0);
      if (sleep_irq_o || wdt_rst_o) seen++;
    end
    check(seen == 0, "R2 unselected source ignored", seen, 0);

    // R3: first interrupt after exactly the interval for each code
    for (int code = 0; code < 4; code++) begin
      step(0, 0, 0, code, 1, 0);
      n = 0; seen = 0;
      while (!seen && n < 300) begin
        step(1, 0, 0, code, 0, 0);
        n++;
        if (sleep_irq_o) seen = 1;
      end
      check(n == interval_ticks(code), "R3 interval length", n, interval_ticks(code));
    end

    // R4: frequent restarts keep both outputs quiet
    step(0, 0, 0, 0, 1, 1);
    seen = 0;
    for (int i = 0; i < 120; i++) begin
      step(1, 0, 0, 0, (i % 3 == 2) ? 1 : 0, 0);
      if (sleep_irq_o || wdt_rst_o) seen++;
    end
    check(seen == 0, "R4 restart holds off", seen, 0);

    // R5: timeout after WDT_PERIODS intervals, then R6 cause behaviour
    step(0, 0, 0, 0, 1, 1);
    n = 0;
    while (!wdt_rst_o && n < 60) begin
      step(1, 0, 0, 0, 0, 0);
      n++;
    end
    check(n == TB_MISS * interval_ticks(0), "R5 timeout ticks", n, TB_MISS * interval_ticks(0));
    n = 1;
    while (wdt_rst_o && n < 20) begin
      step(0, 0, 0, 0, 0, 0);
      if (wdt_rst_o) n++;
    end
    check(n == TB_LEN, "R5 pulse length", n, TB_LEN);
    check(wdt_cause_o == 1'b1, "R6 cause survives pulse", wdt_cause_o, 1);
    step(0, 0, 0, 0, 0, 1);
    check(wdt_cause_o == 1'b0, "R6 cause cleared", wdt_cause_o, 0);

    // R7: toggling the source with both ticks high keeps the count at zero
    seen = 0; src = 0;
    for (int i = 0; i < 90; i++) begin
      if (i % 3 == 0) src = 1 - src;
      step(1, 1, src, 0, 0, 0);
      if (sleep_irq_o || wdt_rst_o) seen++;
    end
    check(seen == 0, "R7 source change clears", seen, 0);

    // R8: switch from longest to shortest code with count low bits at 3
    step(1, 1, 0, 3, 1, 0);
    for (int i = 0; i < 3; i++) step(1, 0, 0, 3, 0, 0);
    step(1, 0, 0, 0, 0, 0);
    check(sleep_irq_o == 1'b1, "R8 period change immediate", sleep_irq_o, 1);

    // Random phase: model comparison every cycle
    src = 0;
    for (int i = 0; i < 4000; i++) begin
      int ps, kk, cc;
      if ($urandom_range(0, 199) == 0) src = 1 - src;
      ps = ($urandom_range(0, 9) < 7) ? 0 : $urandom_range(0, 3);
      kk = ($urandom_range(0, 59) == 0) ? 1 : 0;
      cc = ($urandom_range(0, 29) == 0) ? 1 : 0;
      step($urandom_range(0, 1), $urandom_range(0, 1), src, ps, kk, cc);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule